// File: doc/BRIEF.md
# Snooping TLB Class-Invalidation Unit

This block sits on the snoop side of a two-way set-associative translation lookaside buffer. While the local agent is not bus master, it watches every address tenure on the shared system bus. It picks out broadcast TLB-invalidate transactions that are marked global. From the bus address it takes an 8-bit congruence-class index and, once the tenure has closed cleanly, clears every valid bit of that class. Clearing goes one way per clock.

The block drives the two snoop status outputs: a retry request and a shared indication. It asks for a retry in two cases. The first is a second invalidate that arrives while the single pending slot is still in use. The second is a synchronisation transaction that arrives before all accepted invalidations have been applied. A master that sees a synchronisation complete without retry therefore knows that every earlier invalidation has taken effect. The shared indication is never raised, because the buffer holds no data blocks.

A small fill port sets valid bits, which stands in for the translation side. A probe port reads back one class.

Top module: `snoop_tlbinv`

## Requirements
- R1: A transaction is captured for snooping only when `ts` and `gbl` are both high in the same cycle. When `ts` is seen with `gbl` low, the block gives no retry and no valid bit changes.
- R2: While `bus_master` is high, a transfer start is not snooped. It gives no response and clears nothing.
- R3: The congruence-class index is `addr[19:12]`, counting bit 0 as the least significant address bit. No other address bit has any effect.
- R4: An address tenure ends on the first cycle in which `aack` is high after capture. The snoop response (`artry_out`, `shd_out`) is valid only in the single cycle that follows, called the window. Outside the window `artry_out` is low.
- R5: An invalidate (`tt` = 5'b11000) whose window shows neither `artry_in` nor `artry_out` clears the class. Way 0 reads invalid from the second cycle after the window, and way 1 from the third.
- R6: An invalidation clears all ways of the selected class whatever they hold. Other classes are left unchanged.
- R7: An invalidate whose window sees `artry_in` high leaves the TLB untouched.
- R8: An invalidate whose tenure ends while an earlier invalidation is still pending or clearing gets `artry_out` high in its window and changes nothing.
- R9: A synchronisation transaction (`tt` = 5'b01000) gets `artry_out` high in its window if an invalidation is pending or clearing when its tenure ends. Otherwise it gets no retry.
- R10: `shd_out` is never asserted. Any other `tt` code gets no retry and no state change.
- R11: After reset `artry_out` and `shd_out` are low and every valid bit reads 0.
- R12: `fill_en` sets the valid bit of (`fill_idx`, `fill_way`) in the next cycle. When a fill and a clear hit the same bit in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_master | input | 1 | Local agent owns the bus; snooping is suspended |
| ts | input | 1 | Transfer-start strobe of an address tenure |
| gbl | input | 1 | Transaction is global and must be snooped |
| tt | input | 5 | Transaction type code |
| addr | input | 32 | Bus address |
| aack | input | 1 | Address acknowledge; closes the tenure |
| artry_in | input | 1 | Retry driven by other bus participants |
| artry_out | output | 1 | Retry response of this unit |
| shd_out | output | 1 | Shared response of this unit |
| fill_en | input | 1 | Set one valid bit |
| fill_idx | input | 8 | Class of the fill |
| fill_way | input | 1 | Way of the fill |
| probe_idx | input | 8 | Class to read back |
| probe_valid | output | 2 | Valid bits of the probed class, one per way |

## Verification
The bench builds the block with its defaults: two ways and an 8-bit index at address bit 12. With 256 classes, both end classes 0x00 and 0xFF can be filled and invalidated beside untouched neighbours. The two-cycle clear means that a tenure started right after a window closes while the unit is still busy, so the retry for a second invalidate and for an early synchronisation both come up. A fill placed in the first clear cycle exercises the clear-over-fill priority.

// File: rtl/snoop_tlbinv_pkg.sv
package snoop_tlbinv_pkg;

  localparam int TT_W = 5;

  localparam logic [TT_W-1:0] TT_TLBINV = 5'b11000;
  localparam logic [TT_W-1:0] TT_SYNC   = 5'b01000;

  typedef enum logic [1:0] {
    SK_OTHER = 2'd0,
    SK_INV   = 2'd1,
    SK_SYNC  = 2'd2
  } snoop_kind_e;

  function automatic snoop_kind_e decode_kind(input logic [TT_W-1:0] code);
    if (code == TT_TLBINV) return SK_INV;
    if (code == TT_SYNC)   return SK_SYNC;
    return SK_OTHER;
  endfunction

endpackage

// File: rtl/snoop_tenure_tracker.sv
module snoop_tenure_tracker
  import snoop_tlbinv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 12,
  parameter int IDX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_master,
  input  logic              ts,
  input  logic              gbl,
  input  logic [TT_W-1:0]   tt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aack,
  input  logic              artry_in,
  input  logic              busy,
  output logic              ten_active,
  output logic              artry_out,
  output logic              shd_out,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx
);

  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  // captured tenure
  logic              ten_q, ten_n;
  snoop_kind_e       kind_q, kind_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  // response window
  logic              win_q, win_n;
  snoop_kind_e       wkind_q, wkind_n;
  logic [IDX_W-1:0]  widx_q, widx_n;
  logic              artry_q, artry_n;
  logic              shd_q, shd_n;

  logic capture, close, responds;
  logic addr_unused;

  assign addr_unused = ^{addr[ADDR_W-1:IDX_MSB+1], addr[IDX_LSB-1:0]};

  always_comb begin
    capture  = ts & gbl & ~bus_master & ~ten_q & ~win_q;
    close    = ten_q & aack;
    responds = (kind_q != SK_OTHER);

    ten_n  = ten_q;
    kind_n = kind_q;
    idx_n  = idx_q;
    if (capture) begin
      ten_n  = 1'b1;
      kind_n = decode_kind(tt);
      idx_n  = addr[IDX_MSB:IDX_LSB];
    end else if (close) begin
      ten_n  = 1'b0;
    end

    win_n   = close;
    wkind_n = close ? kind_q : SK_OTHER;
    widx_n  = close ? idx_q : widx_q;
    // retry while the single slot is occupied (invalidate) or not drained (sync)
    artry_n = close & responds & busy;
    // no shared data blocks are ever held
    shd_n   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q  <= 1'b0;
      kind_q <= SK_OTHER;
      idx_q  <= '0;
    end else if (capture | close) begin
      ten_q  <= ten_n;
      kind_q <= kind_n;
      idx_q  <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      wkind_q <= SK_OTHER;
      widx_q  <= '0;
      artry_q <= 1'b0;
      shd_q   <= 1'b0;
    end else begin
      win_q   <= win_n;
      wkind_q <= wkind_n;
      widx_q  <= widx_n;
      artry_q <= artry_n;
      shd_q   <= shd_n;
    end
  end

  assign commit     = win_q & (wkind_q == SK_INV) & ~artry_q & ~artry_in;
  assign commit_idx = widx_q;
  assign ten_active = ten_q;
  assign artry_out  = artry_q;
  assign shd_out    = shd_q;

endmodule

// File: rtl/tlbinv_sequencer.sv
module tlbinv_sequencer #(
  parameter int IDX_W = 8,
  parameter int WAYS  = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 commit,
  input  logic [IDX_W-1:0]                     commit_idx,
  output logic                                 busy,
  output logic                                 clr_en,
  output logic [IDX_W-1:0]                     clr_idx,
  output logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] clr_way
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic             pend_q, pend_n;
  logic [IDX_W-1:0] pidx_q, pidx_n;
  logic [WAY_W-1:0] ptr_q, ptr_n;
  logic             upd;

  always_comb begin
    pend_n = pend_q;
    pidx_n = pidx_q;
    ptr_n  = ptr_q;
    if (pend_q) begin
      if (ptr_q == LAST_WAY) begin
        pend_n = 1'b0;
        ptr_n  = '0;
      end else begin
        ptr_n  = ptr_q + 1'b1;
      end
    end
    if (commit) begin
      pend_n = 1'b1;
      pidx_n = commit_idx;
      ptr_n  = '0;
    end
    upd = pend_q | commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
      ptr_q  <= '0;
    end else if (upd) begin
      pend_q <= pend_n;
      pidx_q <= pidx_n;
      ptr_q  <= ptr_n;
    end
  end

  assign busy    = pend_q;
  assign clr_en  = pend_q;
  assign clr_idx = pidx_q;
  assign clr_way = ptr_q;

endmodule

// File: rtl/tlb_valid_store.sv
module tlb_valid_store #(
  parameter int IDX_W = 8,
  parameter int WAYS  = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fill_en,
  input  logic [IDX_W-1:0]                     fill_idx,
  input  logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] fill_way,
  input  logic                                 clr_en,
  input  logic [IDX_W-1:0]                     clr_idx,
  input  logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0] clr_way,
  input  logic [IDX_W-1:0]                     probe_idx,
  output logic [WAYS-1:0]                      probe_valid
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SETS  = 1 << IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] row_q, row_n;
    logic            fill_hit, clr_hit, upd;

    always_comb begin
      fill_hit = fill_en & (fill_way == WAY_W'(w));
      clr_hit  = clr_en & (clr_way == WAY_W'(w));
      upd      = fill_hit | clr_hit;
      row_n    = row_q;
      if (fill_hit) row_n[fill_idx] = 1'b1;
      // clear is applied last so it overrides a fill to the same bit
      if (clr_hit)  row_n[clr_idx]  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (upd) begin
        row_q <= row_n;
      end
    end

    assign probe_valid[w] = row_q[probe_idx];
  end

endmodule

// File: rtl/snoop_tlbinv.sv
module snoop_tlbinv
  import snoop_tlbinv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 12,
  parameter int IDX_W   = 8,
  parameter int WAYS    = 2,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_master,
  input  logic              ts,
  input  logic              gbl,
  input  logic [TT_W-1:0]   tt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aack,
  input  logic              artry_in,
  output logic              artry_out,
  output logic              shd_out,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [WAYS-1:0]   probe_valid
);

  logic             ten_active;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  logic             inv_busy;
  logic             clr_en;
  logic [IDX_W-1:0] clr_idx;
  logic [WAY_W-1:0] clr_way;

  snoop_tenure_tracker #(
    .ADDR_W (ADDR_W),
    .IDX_LSB(IDX_LSB),
    .IDX_W  (IDX_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_master(bus_master),
    .ts        (ts),
    .gbl       (gbl),
    .tt        (tt),
    .addr      (addr),
    .aack      (aack),
    .artry_in  (artry_in),
    .busy      (inv_busy),
    .ten_active(ten_active),
    .artry_out (artry_out),
    .shd_out   (shd_out),
    .commit    (commit),
    .commit_idx(commit_idx)
  );

  tlbinv_sequencer #(
    .IDX_W(IDX_W),
    .WAYS (WAYS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .commit_idx(commit_idx),
    .busy      (inv_busy),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .clr_way   (clr_way)
  );

  tlb_valid_store #(
    .IDX_W(IDX_W),
    .WAYS (WAYS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .fill_way   (fill_way),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .clr_way    (clr_way),
    .probe_idx  (probe_idx),
    .probe_valid(probe_valid)
  );

endmodule

// File: rtl/snoop_tlbinv_chk.sv
module snoop_tlbinv_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_master,
  input logic ts,
  input logic gbl,
  input logic aack,
  input logic artry_in,
  input logic artry_out,
  input logic ten_active,
  input logic busy
);

  AST_NONGLOBAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ts && !gbl && !ten_active) |=> !ten_active); // R1

  AST_MASTER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ts && bus_master && !ten_active) |=> !ten_active); // R2

  AST_RESP_AFTER_AACK: assert property (@(posedge clk) disable iff (!rst_n)
    artry_out |-> ($past(aack) && $past(ten_active))); // R4

  AST_SINGLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    artry_out |=> !artry_out); // R4

  AST_START_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!artry_in && !artry_out)); // R7

  AST_CLEAR_MULTI_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R5

endmodule

bind snoop_tlbinv snoop_tlbinv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_master(bus_master),
  .ts        (ts),
  .gbl       (gbl),
  .aack      (aack),
  .artry_in  (artry_in),
  .artry_out (artry_out),
  .ten_active(ten_active),
  .busy      (inv_busy)
);

// File: tb/snoop_tlbinv_bench.sv
`timescale 1ns/100ps
module snoop_tlbinv_bench;
  import snoop_tlbinv_pkg::*;

  localparam int WAYS = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_master, ts, gbl, aack, artry_in;
  logic [4:0]  tt;
  logic [31:0] addr;
  logic        artry_out, shd_out;
  logic        fill_en;
  logic [7:0]  fill_idx;
  logic [0:0]  fill_way;
  logic [7:0]  probe_idx;
  logic [1:0]  probe_valid;

  always #2 clk = ~clk;

  snoop_tlbinv u_snoop_tlbinv (
    .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .ts(ts), .gbl(gbl),
    .tt(tt), .addr(addr), .aack(aack), .artry_in(artry_in),
    .artry_out(artry_out), .shd_out(shd_out), .fill_en(fill_en),
    .fill_idx(fill_idx), .fill_way(fill_way), .probe_idx(probe_idx),
    .probe_valid(probe_valid)
  );

  int n_vec = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit m_v[256][2];
  int pq[$];
  int m_phase;
  bit m_ten, m_win, m_artry;
  int m_kind, m_wkind, m_idx, m_widx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[i, j]) m_v[i][j] = 0;
      pq.delete();
      m_phase = 0; m_ten = 0; m_win = 0; m_artry = 0;
      m_kind = 0; m_wkind = 0; m_idx = 0; m_widx = 0;
    end else begin
      bit ten0, win0, busy0, cmt;
      ten0  = m_ten;
      win0  = m_win;
      busy0 = (pq.size() != 0);
      cmt   = m_win && (m_wkind == 1) && !m_artry && !artry_in;
      if (fill_en) m_v[fill_idx][fill_way] = 1;
      if (busy0) begin
        m_v[pq[0]][m_phase] = 0;
        if (m_phase == WAYS - 1) begin
          void'(pq.pop_front());
          m_phase = 0;
        end else m_phase++;
      end
      if (cmt) begin
        pq.push_back(m_widx);
        m_phase = 0;
      end
      if (ten0 && aack) begin
        m_win = 1; m_wkind = m_kind; m_widx = m_idx;
        m_artry = busy0 && (m_kind != 0);
        m_ten = 0;
      end else begin
        m_win = 0; m_artry = 0;
      end
      if (!ten0 && !win0 && ts && gbl && !bus_master) begin
        m_ten = 1;
        m_kind = (tt == 5'b11000) ? 1 : (tt == 5'b01000) ? 2 : 0;
        m_idx = int'(addr[19:12]);
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R4 R8 R9 artry_out vs model", {31'd0, artry_out}, {31'd0, m_artry});
      chk("R10 shd_out vs model", {31'd0, shd_out}, 32'd0);
      chk("R5 R6 R12 probe_valid vs model", {30'd0, probe_valid},
          {30'd0, m_v[probe_idx][1], m_v[probe_idx][0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
    ts = 0; gbl = 0; bus_master = 0; aack = 0; artry_in = 0; fill_en = 0;
  endtask

  task automatic fill(input logic [7:0] idx, input logic w);
    step();
    fill_en = 1; fill_idx = idx; fill_way = w;
  endtask

  task automatic probe(input logic [7:0] idx, input logic [1:0] exp, input string tag);
    probe_idx = idx;
    #0.5;
    chk(tag, {30'd0, probe_valid}, {30'd0, exp});
  endtask

  task automatic xact(input logic [4:0] t, input logic [7:0] idx, input bit g,
                      input bit mst, input int dly, input bit rty,
                      input bit exp, input string tag);
    step();
    ts = 1; gbl = g; bus_master = mst; tt = t; addr = {12'hC3C, idx, 12'h3C3};
    for (int k = 0; k < dly; k++) step();
    step();
    aack = 1;
    @(negedge clk);
    chk("R4 no retry before window", {31'd0, artry_out}, 32'd0);
    step();
    artry_in = rty;
    @(negedge clk);
    chk(tag, {31'd0, artry_out}, {31'd0, exp});
    chk("R10 shd in window", {31'd0, shd_out}, 32'd0);
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_master = 0; ts = 0; gbl = 0; aack = 0; artry_in = 0;
    tt = 0; addr = 0; fill_en = 0; fill_idx = 0; fill_way = 0; probe_idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 reset state
    @(negedge clk);
    chk("R11 artry_out after reset", {31'd0, artry_out}, 32'd0);
    chk("R11 shd_out after reset", {31'd0, shd_out}, 32'd0);
    probe(8'h00, 2'b00, "R11 class 00 clear");
    probe(8'hFF, 2'b00, "R11 class FF clear");

    // R12 fills
    fill(8'h5A, 0); fill(8'h5A, 1); fill(8'h5B, 0);
    fill(8'h00, 0); fill(8'h00, 1); fill(8'hFF, 0); fill(8'hFF, 1);
    fill(8'h11, 0); fill(8'h11, 1); fill(8'h22, 0); fill(8'h22, 1);
    step();
    probe(8'h5A, 2'b11, "R12 fill sets both ways");
    probe(8'h5B, 2'b01, "R12 fill sets one way");

    // R5 R6 R3 clean invalidate of 5A
    xact(5'b11000, 8'h5A, 1, 0, 1, 0, 0, "R5 invalidate accepted");
    step();
    probe(8'h5A, 2'b11, "R5 nothing cleared in first cycle");
    step();
    probe(8'h5A, 2'b10, "R5 way0 cleared first");
    step();
    probe(8'h5A, 2'b00, "R6 all ways cleared");
    probe(8'h5B, 2'b01, "R3 R6 neighbour class untouched");

    // R1 non-global
    xact(5'b11000, 8'hFF, 0, 0, 0, 0, 0, "R1 non-global no response");
    settle();
    probe(8'hFF, 2'b11, "R1 non-global leaves class");

    // R2 own master
    xact(5'b11000, 8'h00, 1, 1, 2, 0, 0, "R2 master no response");
    settle();
    probe(8'h00, 2'b11, "R2 master leaves class");

    // R7 retried by others
    xact(5'b11000, 8'hFF, 1, 0, 0, 1, 0, "R7 retried tenure");
    settle();
    probe(8'hFF, 2'b11, "R7 retried tenure leaves class");

    // R8 second invalidate while busy
    xact(5'b11000, 8'h00, 1, 0, 0, 0, 0, "R8 first invalidate accepted");
    xact(5'b11000, 8'hFF, 1, 0, 0, 0, 1, "R8 busy invalidate retried");
    settle();
    probe(8'h00, 2'b00, "R8 first class cleared");
    probe(8'hFF, 2'b11, "R8 retried class untouched");

    // R9 sync busy then idle
    xact(5'b11000, 8'h11, 1, 0, 0, 0, 0, "R9 invalidate before sync");
    xact(5'b01000, 8'h00, 1, 0, 0, 0, 1, "R9 sync retried while busy");
    xact(5'b01000, 8'h00, 1, 0, 0, 0, 0, "R9 sync clean when idle");
    probe(8'h11, 2'b00, "R9 class cleared by sync completion");

    // R10 other transaction type
    xact(5'b00010, 8'h22, 1, 0, 1, 0, 0, "R10 other type no response");
    settle();
    probe(8'h22, 2'b11, "R10 other type leaves class");

    // R12 clear wins over fill in the same cycle
    xact(5'b11000, 8'h22, 1, 0, 0, 0, 0, "R12 invalidate for overlap");
    fill(8'h22, 0);
    step();
    step();
    probe(8'h22, 2'b00, "R12 clear wins over fill");
    fill(8'h22, 1);
    step();
    probe(8'h22, 2'b10, "R12 refill after clear");

    settle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule